// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer/Counter

This block is a 16-bit counter held as a low and a high byte, paired with a 16-bit capture/reload register. A small internal prescaler divides the clock into a machine-cycle strobe (every `MC_DIV` clocks) and a state strobe (every `ST_DIV` clocks). The counter advances on one of three sources: the machine-cycle strobe (timer function), falling edges on the external count pin (counter function), or the state strobe (baud generation). Software reaches the counter, the reload pair and the control bits through a byte-wide register port.

Three modes share the counter. Capture mode latches the count when the trigger pin falls. Auto-reload mode reloads on overflow and can also count down, with the trigger pin giving the direction. Baud mode reloads on every rollover and emits a one-clock tick for a serial port. The overflow flag and the trigger flag drive an interrupt request. The trigger flag has a different meaning in each mode.

Both pins are sampled only on machine-cycle strobes. A falling edge is a high sample followed by a low sample, and the counter acts on it at the next strobe.

Top module: `multimode_timer16`

## Requirements
- R1: After reset every readable register reads 0x00 (so the up/down enable in the mode register, bit 0 of address 1, is 0 and the direction is up), and `irq` and `baud_tick` are low. The register map is: 0 control, 1 mode, 2 count low, 3 count high, 4 reload low, 5 reload high. Addresses 6 and 7 read 0.
- R2: Control bit 0 is the run bit. With run set, control bit 1 clear and neither baud bit set, the count rises by exactly one in every 12 clocks. With run clear, the count does not change.
- R3: With control bit 1 set, each high-to-low pair of count-pin samples adds exactly one to the count, one machine cycle after the low sample.
- R4: Control bit 7 selects capture mode. In capture mode the count wraps from 0xFFFF to 0x0000 and sets the overflow flag (control bit 5), while the reload pair is left unchanged.
- R5: In capture mode with the trigger enable (control bit 2) set, a falling edge on the trigger pin copies the count into the reload pair and sets the trigger flag (control bit 6). With the trigger enable clear, the same edge changes neither.
- R6: In reload mode counting up, advancing from 0xFFFF loads the reload pair into the count and sets the overflow flag.
- R7: In reload mode with the trigger enable set and up/down disabled, a trigger-pin falling edge loads the reload pair into the count and sets the trigger flag, even while the run bit is clear.
- R8: With up/down enabled in reload mode, a low trigger pin makes the count go down. When the count equals the reload pair, the next step loads 0xFFFF and sets the overflow flag. A high trigger pin makes the count go up, and advancing from 0xFFFF loads the reload pair and sets the overflow flag.
- R9: In up/down mode the trigger flag toggles on every overflow and every underflow, and the trigger flag alone does not assert `irq`.
- R10: Control bits 3 or 4 select baud mode. In baud mode the count advances once every 2 clocks. Rollover from 0xFFFF loads the reload pair and pulses `baud_tick` for exactly one clock, and it never sets the overflow flag.
- R11: In baud mode with the trigger enable set, a trigger-pin falling edge sets the trigger flag and leaves the count unchanged.
- R12: A register-port write to a count byte takes effect even in a cycle where the counter would advance.
- R13: Both flags stay set until software writes them to 0. `irq` is the overflow flag OR the trigger flag, except that the trigger flag is masked in up/down mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_pin | input | 1 | External count input, sampled each machine cycle |
| trig_pin | input | 1 | External trigger and direction input, sampled each machine cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| irq | output | 1 | Interrupt request |
| baud_tick | output | 1 | One-clock pulse on each baud-mode rollover |

## Verification
A register write is visible at the first falling clock edge after the rising edge that takes it. The bench reads at that point, and for R12 it reads before any later edge could matter.

A timer advance arrives once per 12 clocks and a baud advance once per 2 clocks. The strobes run freely, so the bench runs the counter for whole multiples of those periods. It stops the counter with a write that keeps the current flag values. The expected count is then exact, whatever the strobe phase.

A pin edge takes effect at most two machine cycles (24 clocks) after the pin changes. The bench waits 40 clocks before it reads the result. Pin pulses are held for three machine cycles, so every level is sampled.

// File: rtl/tmr_pkg.sv
// Shared register addresses and the control-register layout for the
// multi-mode timer. Assumes a 3-bit register address space.
package tmr_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;

    localparam logic [2:0] A_CTRL   = 3'd0;
    localparam logic [2:0] A_MODE   = 3'd1;
    localparam logic [2:0] A_CNT_LO = 3'd2;
    localparam logic [2:0] A_CNT_HI = 3'd3;
    localparam logic [2:0] A_CAP_LO = 3'd4;
    localparam logic [2:0] A_CAP_HI = 3'd5;

    // Control register, bit 7 down to bit 0.
    typedef struct packed {
        logic cap_sel;   // 7: capture mode
        logic ext_flag;  // 6: trigger flag
        logic ovf_flag;  // 5: overflow flag
        logic tx_baud;   // 4: baud mode request
        logic rx_baud;   // 3: baud mode request
        logic ext_en;    // 2: trigger pin enable
        logic cnt_sel;   // 1: count external pin edges
        logic run;       // 0: run
    } ctrl_t;
endpackage

// File: rtl/tmr_divider.sv
// Free-running clock divider. Emits a one-clock strobe every DIV clocks.
// Assumes DIV >= 2. The strobe phase is set by the release of reset.
module tmr_divider #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic strobe
);
    localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_q;

    // Count from 0 to DIV-1, then wrap to 0.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    assign strobe = (cnt_q == LAST);

    a_r2_strobe_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);
endmodule

// File: rtl/tmr_pin_edge.sv
// Samples a pin on each sample_en strobe and keeps the last two samples.
// On a strobe where the older sample is high and the newer one is low, it
// reports a falling edge, so the event comes one sample period after the
// low sample. Assumes the pin is already synchronous to clk.
module tmr_pin_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    input  logic pin,
    output logic level,
    output logic fall
);
    logic [1:0] hist_q;

    // Shift in a new sample on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         hist_q <= 2'b00;
        else if (sample_en) hist_q <= {hist_q[0], pin};
    end

    assign level = hist_q[0];
    assign fall  = sample_en & hist_q[1] & ~hist_q[0];
endmodule

// File: rtl/tmr_core.sv
// Counter, reload pair, control and mode registers, and the per-mode next
// state logic. Advance and edge inputs must be one-clock pulses. Mode
// priority: baud, then capture, then reload (up/down when enabled).
module tmr_core
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_stb,
    input  logic              st_stb,
    input  logic              cnt_fall,
    input  logic              trig_fall,
    input  logic              trig_level,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              irq,
    output logic              baud_tick
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    ctrl_t            ctrl_q, ctrl_n, ctrl_base;
    logic             updn_q, updn_n;
    logic [CNT_W-1:0] cnt_q, cnt_n, cap_q, cap_n;
    logic             tick_q, tick_n;
    logic             baud_mode, updown, adv, ext_trig, is_max, at_cap;
    logic             set_ovf, set_ext, tog_ext, cnt_wr, ctrl_wr;

    assign baud_mode = ctrl_q.rx_baud | ctrl_q.tx_baud;
    assign updown    = updn_q & ~ctrl_q.cap_sel & ~baud_mode;
    assign adv       = ctrl_q.run & (ctrl_q.cnt_sel ? cnt_fall : (baud_mode ? st_stb : mc_stb));
    assign ext_trig  = ctrl_q.ext_en & trig_fall & ~updown;
    assign is_max    = (cnt_q == ALL_ONES);
    assign at_cap    = (cnt_q == cap_q);
    assign ctrl_wr   = reg_wr && (reg_addr == A_CTRL);
    assign cnt_wr    = reg_wr && ((reg_addr == A_CNT_LO) || (reg_addr == A_CNT_HI));

    // Next-state for the counter, reload pair and flag events, by mode.
    always_comb begin
        cnt_n   = cnt_q;
        cap_n   = cap_q;
        tick_n  = 1'b0;
        set_ovf = 1'b0;
        set_ext = 1'b0;
        tog_ext = 1'b0;
        if (baud_mode) begin
            if (adv) begin
                if (is_max) begin
                    cnt_n  = cap_q;
                    tick_n = 1'b1;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            set_ext = ext_trig;
        end else if (ctrl_q.cap_sel) begin
            if (adv) begin
                cnt_n   = cnt_q + 1'b1;
                set_ovf = is_max;
            end
            if (ext_trig) begin
                cap_n   = cnt_q;
                set_ext = 1'b1;
            end
        end else if (updown) begin
            if (adv) begin
                if (trig_level) begin
                    cnt_n = is_max ? cap_q : cnt_q + 1'b1;
                    set_ovf = is_max;
                end else begin
                    cnt_n = at_cap ? ALL_ONES : cnt_q - 1'b1;
                    set_ovf = at_cap;
                end
                tog_ext = set_ovf;
            end
        end else begin
            if (ext_trig) begin
                cnt_n   = cap_q;
                set_ext = 1'b1;
            end else if (adv) begin
                cnt_n = is_max ? cap_q : cnt_q + 1'b1;
            end
            set_ovf = adv & is_max;
        end
        // Register-port writes override the same-cycle update.
        if (reg_wr && reg_addr == A_CNT_LO) cnt_n[BYTE_W-1:0]     = reg_wdata;
        if (reg_wr && reg_addr == A_CNT_HI) cnt_n[CNT_W-1:BYTE_W] = reg_wdata;
        if (reg_wr && reg_addr == A_CAP_LO) cap_n[BYTE_W-1:0]     = reg_wdata;
        if (reg_wr && reg_addr == A_CAP_HI) cap_n[CNT_W-1:BYTE_W] = reg_wdata;
        updn_n    = (reg_wr && reg_addr == A_MODE) ? reg_wdata[0] : updn_q;
        ctrl_base = ctrl_wr ? ctrl_t'(reg_wdata) : ctrl_q;
        ctrl_n    = ctrl_base;
        ctrl_n.ovf_flag = ctrl_base.ovf_flag | set_ovf;
        ctrl_n.ext_flag = (ctrl_base.ext_flag ^ tog_ext) | set_ext;
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            updn_q <= 1'b0;
            cnt_q  <= '0;
            cap_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            ctrl_q <= ctrl_n;
            updn_q <= updn_n;
            cnt_q  <= cnt_n;
            cap_q  <= cap_n;
            tick_q <= tick_n;
        end
    end

    // Read multiplexer.
    always_comb begin
        case (reg_addr)
            A_CTRL:   reg_rdata = ctrl_q;
            A_MODE:   reg_rdata = {{(BYTE_W-1){1'b0}}, updn_q};
            A_CNT_LO: reg_rdata = cnt_q[BYTE_W-1:0];
            A_CNT_HI: reg_rdata = cnt_q[CNT_W-1:BYTE_W];
            A_CAP_LO: reg_rdata = cap_q[BYTE_W-1:0];
            A_CAP_HI: reg_rdata = cap_q[CNT_W-1:BYTE_W];
            default:  reg_rdata = '0;
        endcase
    end

    assign irq       = ctrl_q.ovf_flag | (ctrl_q.ext_flag & ~updown);
    assign baud_tick = tick_q;

    a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.run && !cnt_wr && !ext_trig) |=> $stable(cnt_q));
    a_r8_underflow_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (updown && adv && !trig_level && at_cap && !cnt_wr) |=> (cnt_q == ALL_ONES));
    a_r9_trig_flag_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (updown && !ctrl_q.ovf_flag) |-> !irq);
    a_r10_no_ovf_in_baud: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_mode && !ctrl_wr) |=> !$rose(ctrl_q.ovf_flag));
    a_r10_tick_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |=> !baud_tick);
endmodule

// File: rtl/multimode_timer16.sv
// Top of the multi-mode 16-bit timer/counter. It holds the two strobe
// dividers, the pin samplers and the core. Assumes the pins are synchronous
// to clk and that MC_DIV and ST_DIV are both at least 2.
module multimode_timer16
    import tmr_pkg::*;
#(
    parameter int MC_DIV = 12,
    parameter int ST_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cnt_pin,
    input  logic       trig_pin,
    input  logic       reg_wr,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic       baud_tick
);
    logic mc_stb, st_stb, cnt_fall, cnt_level, trig_fall, trig_level;
    logic [1:0] div_stb;

    // One divider per strobe rate.
    for (genvar g = 0; g < 2; g++) begin : g_div
        tmr_divider #(.DIV(g == 0 ? MC_DIV : ST_DIV)) i_div (
            .clk(clk), .rst_n(rst_n), .strobe(div_stb[g]));
    end
    assign mc_stb = div_stb[0];
    assign st_stb = div_stb[1];

    tmr_pin_edge i_cnt_edge (
        .clk(clk), .rst_n(rst_n), .sample_en(mc_stb), .pin(cnt_pin),
        .level(cnt_level), .fall(cnt_fall));

    tmr_pin_edge i_trig_edge (
        .clk(clk), .rst_n(rst_n), .sample_en(mc_stb), .pin(trig_pin),
        .level(trig_level), .fall(trig_fall));

    tmr_core i_core (
        .clk(clk), .rst_n(rst_n), .mc_stb(mc_stb), .st_stb(st_stb),
        .cnt_fall(cnt_fall & cnt_level == 1'b0), .trig_fall(trig_fall),
        .trig_level(trig_level), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .baud_tick(baud_tick));
endmodule

// File: tb/test_multimode_timer16.sv
module test_multimode_timer16;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_pin = 1'b1;
    logic       trig_pin = 1'b1;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq, baud_tick;
    int checks = 0;
    int errors = 0;
    int ticks = 0;

    multimode_timer16 i_multimode_timer16 (
        .clk(clk), .rst_n(rst_n), .cnt_pin(cnt_pin), .trig_pin(trig_pin),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .baud_tick(baud_tick));

    always #10 clk = ~clk;

    always @(negedge clk) if (baud_tick) ticks++;

    // Control bit values.
    localparam logic [7:0] RUN = 8'h01, CSEL = 8'h02, EXEN = 8'h04, RXB = 8'h08,
                           OVF = 8'h20, EXF = 8'h40, CAPM = 8'h80;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        reg_addr = a; #1; v = reg_rdata;
    endtask

    task automatic rd_cnt(output int v);
        logic [7:0] lo, hi;
        rd(3'd2, lo); rd(3'd3, hi); v = {hi, lo};
    endtask

    task automatic rd_cap(output int v);
        logic [7:0] lo, hi;
        rd(3'd4, lo); rd(3'd5, hi); v = {hi, lo};
    endtask

    task automatic setup(input int cnt, input int cap);
        wr(3'd2, cnt[7:0]); wr(3'd3, cnt[15:8]);
        wr(3'd4, cap[7:0]); wr(3'd5, cap[15:8]);
    endtask

    // Run for exactly n clock edges, then stop while keeping the flags.
    task automatic run_for(input logic [7:0] c, input int n);
        logic [7:0] v;
        wr(3'd0, c | RUN);
        repeat (n - 1) @(negedge clk);
        rd(3'd0, v);
        wr(3'd0, v & ~RUN);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v;
        logic [7:0] b;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), b); chk("R1 register reset", b, 0);
        end
        chk("R1 irq reset", irq, 0);
        chk("R1 tick reset", baud_tick, 0);

        // R2: timer rate, 10 machine cycles
        setup(16'h0100, 16'h0000);
        run_for(8'h00, 120);
        rd_cnt(v); chk("R2 timer advance", v, 16'h010A);
        repeat (100) @(negedge clk);
        rd_cnt(v); chk("R2 stopped holds", v, 16'h010A);

        // R3: five slow pulses on the count pin
        setup(16'h0000, 16'h0000);
        wr(3'd0, CSEL | RUN);
        for (int i = 0; i < 5; i++) begin
            cnt_pin = 1'b0; repeat (36) @(negedge clk);
            cnt_pin = 1'b1; repeat (36) @(negedge clk);
        end
        repeat (48) @(negedge clk);
        wr(3'd0, 8'h00);
        rd_cnt(v); chk("R3 pin edges counted", v, 5);

        // R4: capture-mode wrap
        setup(16'hFFFE, 16'h0BAD);
        run_for(CAPM, 24);
        rd_cnt(v); chk("R4 wrap to zero", v, 0);
        rd(3'd0, b); chk("R4 overflow flag", b[5], 1);
        rd_cap(v); chk("R4 reload pair kept", v, 16'h0BAD);

        // R5: capture on trigger edge, then ignored without enable
        wr(3'd0, CAPM | EXEN);
        setup(16'hABCD, 16'h0000);
        trig_pin = 1'b0; repeat (40) @(negedge clk);
        rd_cap(v); chk("R5 captured count", v, 16'hABCD);
        rd(3'd0, b); chk("R5 trigger flag set", b[6], 1);
        chk("R13 irq from trigger flag", irq, 1);
        trig_pin = 1'b1; repeat (40) @(negedge clk);
        wr(3'd0, CAPM);
        setup(16'h1111, 16'h2222);
        trig_pin = 1'b0; repeat (40) @(negedge clk);
        rd_cap(v); chk("R5 no capture when disabled", v, 16'h2222);
        rd(3'd0, b); chk("R5 no flag when disabled", b[6], 0);
        trig_pin = 1'b1; repeat (40) @(negedge clk);

        // R6: reload on overflow, counting up
        wr(3'd0, 8'h00);
        setup(16'hFFFE, 16'h8000);
        run_for(8'h00, 36);
        rd_cnt(v); chk("R6 reload then advance", v, 16'h8001);
        rd(3'd0, b); chk("R6 overflow flag", b[5], 1);

        // R13: flags sticky until written to 0
        repeat (200) @(negedge clk);
        rd(3'd0, b); chk("R13 flag sticky", b[5], 1);
        chk("R13 irq with overflow", irq, 1);
        wr(3'd0, 8'h00);
        chk("R13 irq cleared", irq, 0);

        // R7: trigger-forced reload while stopped
        wr(3'd0, EXEN);
        setup(16'h0005, 16'h4444);
        trig_pin = 1'b0; repeat (40) @(negedge clk);
        rd_cnt(v); chk("R7 forced reload", v, 16'h4444);
        rd(3'd0, b); chk("R7 trigger flag", b[6], 1);
        trig_pin = 1'b1; repeat (40) @(negedge clk);

        // R8/R9: down count to the reload value, then up from all ones
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h01);
        setup(16'h0012, 16'h0010);
        trig_pin = 1'b0; repeat (40) @(negedge clk);
        run_for(8'h00, 36);
        rd_cnt(v); chk("R8 underflow loads all ones", v, 16'hFFFF);
        rd(3'd0, b); chk("R8 underflow overflow flag", b[5], 1);
        chk("R9 trigger flag toggled on", b[6], 1);
        wr(3'd0, EXF);
        chk("R9 irq masked in up/down", irq, 0);
        trig_pin = 1'b1; repeat (40) @(negedge clk);
        run_for(EXF, 12);
        rd_cnt(v); chk("R8 up overflow reloads", v, 16'h0010);
        rd(3'd0, b); chk("R9 trigger flag toggled off", b[6], 0);
        chk("R8 up overflow flag", b[5], 1);
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h00);

        // R10: baud rate and rollover
        setup(16'h0100, 16'h1234);
        run_for(RXB, 20);
        rd_cnt(v); chk("R10 baud rate", v, 16'h010A);
        setup(16'hFFFE, 16'h1234);
        ticks = 0;
        run_for(RXB, 4);
        @(negedge clk);
        rd_cnt(v); chk("R10 rollover reload", v, 16'h1234);
        chk("R10 one tick", ticks, 1);
        rd(3'd0, b); chk("R10 no overflow flag", b[5], 0);

        // R11: trigger edge in baud mode
        wr(3'd0, RXB | EXEN);
        setup(16'h0042, 16'h1234);
        trig_pin = 1'b0; repeat (40) @(negedge clk);
        rd_cnt(v); chk("R11 count unchanged", v, 16'h0042);
        rd(3'd0, b); chk("R11 trigger flag", b[6], 1);
        trig_pin = 1'b1; repeat (40) @(negedge clk);

        // R12: writes win while counting every other clock
        wr(3'd0, RXB | RUN);
        wr(3'd2, 8'h55);
        rd(3'd2, b); chk("R12 write wins first", b, 8'h55);
        wr(3'd2, 8'h77);
        rd(3'd2, b); chk("R12 write wins second", b, 8'h77);
        wr(3'd0, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule